// File: doc/BRIEF.md
# Paged ring-buffer data port

This block is a programmed-I/O engine. It lets a 16-bit host register port reach a packet buffer RAM that is only one byte wide. The host loads a store pointer for outgoing data and a fetch pointer for incoming data. It then moves whole 16-bit words through a single data register. Each word is split into, or assembled from, two byte-wide RAM cycles in sequence, and the pointer in use advances by itself after each word.

Received frames sit in a ring made of 256-byte pages. A ring-bounds register holds the first ring page and the last ring page. When the fetch pointer steps past the final byte of the last ring page, it continues at offset zero of the first ring page. Software can therefore read a frame that straddles the physical end of the ring as one unbroken block.

After the fetch pointer is loaded, and after every data-register read, the next word is prefetched into a latch. A ready signal stays low while any RAM sequence is running. A host access is only taken while ready is high.

Top module: `pio_ring_port`

## Requirements
- R1: After reset, `hostReady` is 1, the store and fetch pointers read back as 0, and the bounds register reads back as 0x7F00 (last page 0x7F in the high byte, first ring page 0x00 in the low byte).
- R2: Register select `hostAddr` maps as follows: 0 is the store pointer, 1 is the fetch pointer, 2 is the bounds register, and 3 is the data register. Writes to 0, 1 and 2 take effect, and pointers and bounds read back zero-extended to 16 bits.
- R3: A data-register write performs two RAM writes on consecutive cycles, with `hostReady` low. The low byte goes to the store pointer address and the high byte to that address plus one. Both bytes are stored exactly as given, so a host that pads an odd-length tail with a zero high byte gets that zero stored.
- R4: After each data-register write, the store pointer advances by 2. It never wraps: it stops at the last word address of the buffer (0x7FFE by default) and holds there.
- R5: Loading the fetch pointer drops `hostReady` on the next cycle. It stays low until the word at that address is latched. The next data read then returns {byte at address+1, byte at address}.
- R6: Each data-register read returns the latched word and starts the prefetch of the following word, dropping `hostReady`. The fetch pointer reads back as the address of the next byte to be fetched, which is two bytes past the latched word.
- R7: Each fetched byte address advances by one. The exception is the byte at offset 0xFF of the last ring page: the next address is offset 0x00 of the first ring page. This holds for a word that starts at an odd address and is split across the wrap. The bounds register takes effect for the next fetch.
- R8: A host access presented while `hostReady` is low is ignored. It causes no RAM write and changes no pointer or the bounds register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| hostSel | input | 1 | Host access request for this cycle |
| hostWr | input | 1 | 1 for a write, 0 for a read |
| hostAddr | input | 2 | Register select |
| hostWdata | input | 16 | Host write data |
| hostRdata | output | 16 | Host read data for the selected register |
| hostReady | output | 1 | High when an access can be taken |
| ramAddr | output | ADDR_W (15) | Byte address to the buffer RAM |
| ramWe | output | 1 | Buffer RAM write enable |
| ramWdata | output | 8 | Byte written to the RAM |
| ramRdata | input | 8 | Byte read from the RAM, one cycle after its address |

## Verification
Fetch streams are run from several starting points:
- a block wholly inside an ordinary page;
- a block crossing a plain page boundary, which shows that only the last ring page wraps;
- a block running off the last ring page;
- a block starting on the last odd byte, so one word holds bytes from both ends of the ring.

A second bounds setting shows that the wrap point follows the register and is not fixed. Stores include an odd-length tail with a zero pad and a run into the top of the buffer, which separates saturation from wrap-around. Accesses thrown at the port during a prefetch must leave the RAM, the pointers and the bounds register untouched.

// File: rtl/pio_ring_pkg.sv
package pio_ring_pkg;

  // Register select codes seen on hostAddr
  localparam logic [1:0] REG_STORE = 2'd0;
  localparam logic [1:0] REG_FETCH = 2'd1;
  localparam logic [1:0] REG_BOUND = 2'd2;
  localparam logic [1:0] REG_DATA  = 2'd3;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FETCH_A,   // low byte address on RAM
    ST_FETCH_B,   // high byte address on RAM, low byte returning
    ST_FETCH_C,   // high byte returning
    ST_STORE_A,   // low byte written
    ST_STORE_B    // high byte written
  } portState_t;

  typedef struct packed {
    logic ldStore;    // load store pointer from host
    logic ldFetch;    // load fetch pointer from host
    logic ldBound;    // load ring bounds register
    logic ldOutWord;  // capture host word for writing
    logic fetchStep;  // advance fetch pointer one byte
    logic capLo;      // capture returning byte into low lane
    logic capHi;      // capture returning byte into high lane
    logic wrLo;       // write low byte of the output word
    logic wrHi;       // write high byte, then advance store pointer
  } portStrobes_t;

endpackage

// File: rtl/pio_ring_ctrl.sv
module pio_ring_ctrl
  import pio_ring_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         hostSel,
  input  logic         hostWr,
  input  logic [1:0]   hostAddr,
  output portStrobes_t strobes,
  output logic         hostReady
);

  portState_t state, stateNext;
  logic       accept;

  assign hostReady = (state == ST_IDLE);
  assign accept    = hostSel && hostReady;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    stateNext = state;
    strobes   = '0;
    unique case (state)
      ST_IDLE: begin
        if (accept) begin
          if (hostWr) begin
            unique case (hostAddr)
              REG_STORE: strobes.ldStore = 1'b1;
              REG_FETCH: begin
                strobes.ldFetch = 1'b1;
                stateNext       = ST_FETCH_A;
              end
              REG_BOUND: strobes.ldBound = 1'b1;
              REG_DATA: begin
                strobes.ldOutWord = 1'b1;
                stateNext         = ST_STORE_A;
              end
              default: stateNext = ST_IDLE;
            endcase
          end else if (hostAddr == REG_DATA) begin
            stateNext = ST_FETCH_A;
          end
        end
      end
      ST_FETCH_A: begin
        strobes.fetchStep = 1'b1;
        stateNext         = ST_FETCH_B;
      end
      ST_FETCH_B: begin
        strobes.fetchStep = 1'b1;
        strobes.capLo     = 1'b1;
        stateNext         = ST_FETCH_C;
      end
      ST_FETCH_C: begin
        strobes.capHi = 1'b1;
        stateNext     = ST_IDLE;
      end
      ST_STORE_A: begin
        strobes.wrLo = 1'b1;
        stateNext    = ST_STORE_B;
      end
      ST_STORE_B: begin
        strobes.wrHi = 1'b1;
        stateNext    = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

endmodule

// File: rtl/pio_ring_dp.sv
module pio_ring_dp
  import pio_ring_pkg::*;
#(
  parameter int NUM_PAGES = 128,
  localparam int PAGE_W = $clog2(NUM_PAGES),
  localparam int ADDR_W = PAGE_W + 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  portStrobes_t      strobes,
  input  logic [1:0]        hostAddr,
  input  logic [15:0]       hostWdata,
  output logic [15:0]       hostRdata,
  output logic [ADDR_W-1:0] ramAddr,
  output logic              ramWe,
  output logic [7:0]        ramWdata,
  input  logic [7:0]        ramRdata,
  output logic [15:0]       boundQ
);

  localparam logic [ADDR_W-1:0] ONE  = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] TWO  = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] TOP  = ADDR_W'(NUM_PAGES * 256 - 2);
  localparam logic [7:0]        LAST = 8'(NUM_PAGES - 1);

  logic [ADDR_W-1:0] storePtr, storeNext;
  logic [ADDR_W-1:0] fetchPtr, fetchNext;
  logic [7:0]        ringFirst, ringLast;
  logic [15:0]       outWord;
  logic [15:0]       inWord;
  logic              atRingEnd;

  // Byte-granular fetch step with the ring wrap folded in
  assign atRingEnd = (fetchPtr[7:0] == 8'hFF) &&
                     (fetchPtr[ADDR_W-1:8] == ringLast[PAGE_W-1:0]);

  always_comb begin
    if (atRingEnd) fetchNext = {ringFirst[PAGE_W-1:0], 8'h00};
    else           fetchNext = fetchPtr + ONE;
  end

  // Store pointer: word step, saturating at the last word of the buffer
  always_comb begin
    if (storePtr >= TOP)           storeNext = storePtr;
    else if (storePtr > TOP - TWO) storeNext = TOP;
    else                           storeNext = storePtr + TWO;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      storePtr  <= '0;
      fetchPtr  <= '0;
      ringFirst <= 8'h00;
      ringLast  <= LAST;
      outWord   <= '0;
    end else begin
      if (strobes.ldStore)    storePtr <= hostWdata[ADDR_W-1:0];
      else if (strobes.wrHi)  storePtr <= storeNext;

      if (strobes.ldFetch)        fetchPtr <= hostWdata[ADDR_W-1:0];
      else if (strobes.fetchStep) fetchPtr <= fetchNext;

      if (strobes.ldBound) begin
        ringFirst <= hostWdata[7:0];
        ringLast  <= hostWdata[15:8];
      end

      if (strobes.ldOutWord) outWord <= hostWdata;
    end
  end

  // Read latch: one byte lane per capture strobe
  logic [1:0] laneCap;
  assign laneCap = {strobes.capHi, strobes.capLo};

  for (genvar lane = 0; lane < 2; lane++) begin : g_lane
    always_ff @(posedge clk) begin
      if (!rstN)              inWord[lane*8 +: 8] <= 8'h00;
      else if (laneCap[lane]) inWord[lane*8 +: 8] <= ramRdata;
    end
  end

  // RAM side
  always_comb begin
    if (strobes.wrLo)      ramAddr = storePtr;
    else if (strobes.wrHi) ramAddr = storePtr + ONE;
    else                   ramAddr = fetchPtr;
  end

  assign ramWe    = strobes.wrLo | strobes.wrHi;
  assign ramWdata = strobes.wrHi ? outWord[15:8] : outWord[7:0];

  // Host read mux
  assign boundQ = {ringLast, ringFirst};

  always_comb begin
    unique case (hostAddr)
      REG_STORE: hostRdata = 16'(storePtr);
      REG_FETCH: hostRdata = 16'(fetchPtr);
      REG_BOUND: hostRdata = boundQ;
      default:   hostRdata = inWord;
    endcase
  end

endmodule

// File: rtl/pio_ring_port.sv
module pio_ring_port
  import pio_ring_pkg::*;
#(
  parameter int NUM_PAGES = 128,
  localparam int ADDR_W = $clog2(NUM_PAGES) + 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostSel,
  input  logic              hostWr,
  input  logic [1:0]        hostAddr,
  input  logic [15:0]       hostWdata,
  output logic [15:0]       hostRdata,
  output logic              hostReady,
  output logic [ADDR_W-1:0] ramAddr,
  output logic              ramWe,
  output logic [7:0]        ramWdata,
  input  logic [7:0]        ramRdata
);

  portStrobes_t strobes;
  logic [15:0]  boundQ;

  pio_ring_ctrl ctrlI (
    .clk       (clk),
    .rstN      (rstN),
    .hostSel   (hostSel),
    .hostWr    (hostWr),
    .hostAddr  (hostAddr),
    .strobes   (strobes),
    .hostReady (hostReady)
  );

  pio_ring_dp #(.NUM_PAGES(NUM_PAGES)) dpI (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .hostAddr  (hostAddr),
    .hostWdata (hostWdata),
    .hostRdata (hostRdata),
    .ramAddr   (ramAddr),
    .ramWe     (ramWe),
    .ramWdata  (ramWdata),
    .ramRdata  (ramRdata),
    .boundQ    (boundQ)
  );

endmodule

// File: rtl/pio_ring_port_chk.sv
module pio_ring_port_chk #(
  parameter int ADDR_W = 15
) (
  input logic              clk,
  input logic              rstN,
  input logic              hostSel,
  input logic              hostWr,
  input logic [1:0]        hostAddr,
  input logic              hostReady,
  input logic              ramWe,
  input logic [ADDR_W-1:0] ramAddr,
  input logic [15:0]       boundQ
);

  // R3
  store_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    ramWe |-> !hostReady);

  // R3
  store_pair_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ramWe && !$past(ramWe)) |=> (ramWe && ramAddr == ADDR_W'($past(ramAddr) + 1)));

  // R5
  fetch_load_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    (hostSel && hostWr && hostAddr == 2'd1 && hostReady) |=> !hostReady);

  // R6
  data_read_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    (hostSel && !hostWr && hostAddr == 2'd3 && hostReady) |=> !hostReady);

  // R8
  bound_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !hostReady |=> $stable(boundQ));

endmodule

bind pio_ring_port pio_ring_port_chk #(.ADDR_W(ADDR_W)) chkI (
  .clk       (clk),
  .rstN      (rstN),
  .hostSel   (hostSel),
  .hostWr    (hostWr),
  .hostAddr  (hostAddr),
  .hostReady (hostReady),
  .ramWe     (ramWe),
  .ramAddr   (ramAddr),
  .boundQ    (boundQ)
);

// File: tb/tb_pio_ring_port.sv
`timescale 1ns/100ps
module tb_pio_ring_port;

  localparam int NUM_PAGES = 128;
  localparam int ADDR_W    = 15;
  localparam int TOPW      = NUM_PAGES * 256 - 2;
  localparam int AMASK     = NUM_PAGES * 256 - 1;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              hostSel = 1'b0;
  logic              hostWr = 1'b0;
  logic [1:0]        hostAddr = 2'd0;
  logic [15:0]       hostWdata = 16'h0;
  logic [15:0]       hostRdata;
  logic              hostReady;
  logic [ADDR_W-1:0] ramAddr;
  logic              ramWe;
  logic [7:0]        ramWdata;
  logic [7:0]        ramRdata = 8'h00;

  always #2 clk = ~clk;

  pio_ring_port #(.NUM_PAGES(NUM_PAGES)) dut (
    .clk(clk), .rstN(rstN), .hostSel(hostSel), .hostWr(hostWr),
    .hostAddr(hostAddr), .hostWdata(hostWdata), .hostRdata(hostRdata),
    .hostReady(hostReady), .ramAddr(ramAddr), .ramWe(ramWe),
    .ramWdata(ramWdata), .ramRdata(ramRdata)
  );

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  // RAM model with a computed background pattern
  logic [7:0] mem [int];

  function automatic logic [7:0] seedByte(int a);
    return 8'(a) ^ 8'(a >> 7) ^ 8'hA5;
  endfunction

  function automatic logic [7:0] byteAt(int a);
    if (mem.exists(a)) return mem[a];
    return seedByte(a);
  endfunction

  always @(posedge clk) begin
    ramRdata <= byteAt(int'(ramAddr));
    if (ramWe) mem[int'(ramAddr)] = ramWdata;
  end

  // Bench model of the pointers and ring
  int ringFirst = 0;
  int ringLast  = NUM_PAGES - 1;
  int storeP    = 0;
  int wordP     = 0;

  function automatic int stepByte(int a);
    if ((a & 255) == 255 && (a >> 8) == ringLast) return ringFirst << 8;
    return (a + 1) & AMASK;
  endfunction

  task automatic check(bit ok, string req, string what, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Scoreboard queues
  logic [15:0] expRd[$];
  string       tagRd[$];
  logic [22:0] expWr[$];
  string       tagWr[$];
  logic [15:0] popRd;
  logic [22:0] popWr;
  string       popTag;

  always @(negedge clk) begin
    if (rstN && !done) begin
      if (hostSel && !hostWr && hostAddr == 2'd3 && hostReady) begin
        if (expRd.size() == 0) check(1'b0, "R6", "unexpected data read", int'(hostRdata), 0);
        else begin
          popRd  = expRd.pop_front();
          popTag = tagRd.pop_front();
          check(hostRdata == popRd, popTag, "data word", int'(hostRdata), int'(popRd));
        end
      end
      if (ramWe) begin
        if (expWr.size() == 0) check(1'b0, "R8", "unexpected RAM write", int'({ramAddr, ramWdata}), 0);
        else begin
          popWr  = expWr.pop_front();
          popTag = tagWr.pop_front();
          check({ramAddr, ramWdata} == popWr, popTag, "RAM write {addr,byte}",
                int'({ramAddr, ramWdata}), int'(popWr));
        end
      end
    end
  end

  // Driver
  task automatic hostCycle(input bit wr, input logic [1:0] a, input logic [15:0] d,
                           output logic [15:0] q);
    do begin @(posedge clk); #1; end while (!hostReady);
    hostSel = 1'b1; hostWr = wr; hostAddr = a; hostWdata = d;
    @(negedge clk);
    q = hostRdata;
    @(posedge clk); #1;
    hostSel = 1'b0; hostWr = 1'b0;
  endtask

  task automatic regWrite(logic [1:0] a, logic [15:0] d);
    logic [15:0] q;
    hostCycle(1'b1, a, d, q);
  endtask

  task automatic regCheck(logic [1:0] a, int exp, string req, string what);
    logic [15:0] q;
    hostCycle(1'b0, a, 16'h0, q);
    check(q == 16'(exp), req, what, int'(q), exp);
  endtask

  task automatic setBound(int first, int last);
    regWrite(2'd2, 16'((last << 8) | first));
    ringFirst = first; ringLast = last;
  endtask

  task automatic setStore(int a);
    regWrite(2'd0, 16'(a));
    storeP = a;
  endtask

  task automatic setFetch(int a, string req);
    regWrite(2'd1, 16'(a));
    check(hostReady == 1'b0, req, "ready low after fetch load", int'(hostReady), 0);
    wordP = a;
  endtask

  task automatic readWords(int n, string req);
    logic [15:0] q;
    for (int i = 0; i < n; i++) begin
      expRd.push_back({byteAt(stepByte(wordP)), byteAt(wordP)});
      tagRd.push_back(req);
      hostCycle(1'b0, 2'd3, 16'h0, q);
      wordP = stepByte(stepByte(wordP));
    end
  endtask

  task automatic writeWord(logic [15:0] d, string req);
    logic [15:0] q;
    expWr.push_back({ADDR_W'(storeP), d[7:0]});
    tagWr.push_back(req);
    expWr.push_back({ADDR_W'(storeP + 1), d[15:8]});
    tagWr.push_back(req);
    hostCycle(1'b1, 2'd3, d, q);
    if (storeP >= TOPW)          storeP = storeP;
    else if (storeP + 2 > TOPW)  storeP = TOPW;
    else                         storeP = storeP + 2;
  endtask

  // Watchdog
  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (4) @(posedge clk);
    #1 rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(hostReady == 1'b1, "R1", "ready after reset", int'(hostReady), 1);
    regCheck(2'd0, 0, "R1", "store pointer after reset");
    regCheck(2'd1, 0, "R1", "fetch pointer after reset");
    regCheck(2'd2, 16'h7F00, "R1", "bounds after reset");

    // R2 register map
    setBound(8'h0C, 8'h7F);
    regCheck(2'd2, 16'h7F0C, "R2", "bounds readback");
    setStore(16'h0600);
    regCheck(2'd0, 16'h0600, "R2", "store pointer readback");

    // R3 word stores, including an odd tail padded with zero
    writeWord(16'h1234, "R3");
    writeWord(16'hABCD, "R3");
    writeWord(16'h0077, "R3");
    regCheck(2'd0, 16'h0606, "R4", "store pointer after three words");

    // R5 prefetch and word assembly, R6 stepping
    setFetch(16'h0600, "R5");
    readWords(3, "R5");
    regCheck(2'd1, stepByte(stepByte(wordP)), "R6", "fetch pointer ahead of latch");

    // R7 plain page crossing, not the last ring page
    setFetch(16'h10FE, "R7");
    readWords(2, "R7");

    // R7 wrap at the end of the ring
    setFetch(16'h7FF8, "R7");
    readWords(6, "R7");
    regCheck(2'd1, 16'h0C06, "R7", "fetch pointer after wrap");

    // R7 odd start: one word split across the wrap
    setFetch(16'h7FFF, "R7");
    readWords(2, "R7");

    // R7 different bounds move the wrap point
    setBound(8'h20, 8'h3F);
    setFetch(16'h3FFE, "R7");
    readWords(2, "R7");
    setBound(8'h0C, 8'h7F);

    // R4 saturation at the top of the buffer
    setStore(16'h7FFA);
    writeWord(16'h1111, "R4");
    writeWord(16'h2222, "R4");
    writeWord(16'h3333, "R4");
    writeWord(16'h4444, "R4");
    regCheck(2'd0, TOPW, "R4", "store pointer saturated");
    setFetch(16'h7FFA, "R4");
    readWords(3, "R4");

    // R8 accesses while busy are ignored
    setStore(16'h0700);
    regWrite(2'd1, 16'h0900);
    wordP = 16'h0900;
    hostSel = 1'b1; hostWr = 1'b1; hostAddr = 2'd3; hostWdata = 16'hDEAD;
    @(posedge clk); #1;
    hostAddr = 2'd2; hostWdata = 16'h0101;
    @(posedge clk); #1;
    hostAddr = 2'd0; hostWdata = 16'h0123;
    @(posedge clk); #1;
    hostSel = 1'b0; hostWr = 1'b0;
    regCheck(2'd2, 16'h7F0C, "R8", "bounds unchanged by busy write");
    regCheck(2'd0, 16'h0700, "R8", "store pointer unchanged by busy write");
    readWords(2, "R8");

    repeat (6) @(posedge clk);
    #1;
    check(expRd.size() == 0, "R6", "read scoreboard drained", expRd.size(), 0);
    check(expWr.size() == 0, "R3", "write scoreboard drained", expWr.size(), 0);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule